// File: doc/BRIEF.md
# DMA Global Control and Interrupt Aggregator

This block is the shared control point for a bank of DMA channel engines. It sits behind a 32-bit register slave port and holds three things. The first is the global enable. The second is a pair of sticky global flags, address error and halt. The hardware sets these flags and software clears them. The block also owns a per-channel interrupt pending register and a per-channel doorbell register.

Each channel raises a level interrupt request. The block detects the rising edge of that request and records it as a pending bit. Software clears pending bits with a read-modify-write. The pending bits, gated by the global enable, are OR-ed into one interrupt line.

Software announces a ready descriptor through a write-one-to-set alias of the doorbell register. Each doorbell bit stays set until its channel acknowledges it. The block also drives a start-permit level to the channels. The permit is high only while the block is enabled and neither global flag is set.

Top module: `dma_glb_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the enable, both flags, all pending bits and all doorbell bits are 0. The interrupt line and the start permit are low.
- R2: The control register is at byte offset 0x1000. A write stores data bit 0 as the global enable, and a read returns it in bit 0. Bit 2 reads as the address-error flag and bit 3 reads as the halt flag. All other bits read 0.
- R3: A pulse on `err_set` sets the address-error flag and a pulse on `halt_set` sets the halt flag. A control write with 0 in bit 2 (or bit 3) clears that flag, and a 1 leaves it unchanged. When a hardware set and a clearing write arrive in the same cycle, the set wins.
- R4: `start_ok` is high exactly when the enable is 1 and both global flags are 0.
- R5: The pending register is at offset 0x1004, and bit n belongs to channel n. A 0-to-1 transition of `chan_irq[n]` sets pending bit n on the next clock edge. A request held high does not set the bit again.
- R6: A write to the pending register clears each bit written as 0 and leaves each bit written as 1 unchanged. A write never sets a bit.
- R7: If a rising request on channel n and a write clearing bit n arrive in the same cycle, pending bit n ends up set.
- R8: `irq_out` is high exactly when the enable is 1 and at least one pending bit is set.
- R9: A write to offset 0x100C sets every doorbell bit whose data bit is 1 and leaves the others unchanged. A read of 0x100C returns 0.
- R10: The doorbell register reads at offset 0x1008 and on `db_vec`. Writes to 0x1008 have no effect.
- R11: A high `db_ack[n]` clears doorbell bit n on the next edge. If a set of bit n at 0x100C arrives in the same cycle, the bit stays set.
- R12: Reads of any other offset return 0, and writes to any other offset change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_sel | input | 1 | Register access valid |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data (combinational from address) |
| err_set | input | 1 | Hardware pulse that raises the address-error flag |
| halt_set | input | 1 | Hardware pulse that raises the halt flag |
| chan_irq | input | NCH | Per-channel interrupt request levels |
| db_ack | input | NCH | Per-channel descriptor acceptance |
| db_vec | output | NCH | Doorbell bits, one per channel |
| glb_en | output | 1 | Global enable |
| start_ok | output | 1 | Channels may start |
| irq_out | output | 1 | Combined interrupt |

## Verification
The bench builds the block with the default of 32 channels and a 13-bit offset. With 32 channels the pending and doorbell registers fill the whole data word, so bit 31 and the top-bit edge of each vector are reachable. The low channels and the bit-31 end are exercised against read-back through the register port. A 13-bit offset also makes the control, pending, doorbell and set-alias offsets distinct from unmapped neighbours such as 0x1010 and 0x0000. This lets the bench show that accesses to those neighbours are ignored.

// File: rtl/dma_glb_pkg.sv
// Package: shared offsets and control-bit positions for the DMA global block.
// Assumes byte offsets compared in full; the data word is 32 bits.
package dma_glb_pkg;
    localparam int DW = 32;
    localparam logic [12:0] OFS_CTRL   = 13'h1000;
    localparam logic [12:0] OFS_PEND   = 13'h1004;
    localparam logic [12:0] OFS_DBELL  = 13'h1008;
    localparam logic [12:0] OFS_DBSET  = 13'h100C;
    localparam int BIT_EN   = 0;
    localparam int BIT_ERR  = 2;
    localparam int BIT_HALT = 3;
endpackage

// File: rtl/dma_glb_flags.sv
// Module: global enable and sticky error/halt flags.
// Assumes we is a one-cycle control-register write strobe; hardware set wins.
module dma_glb_flags
    import dma_glb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [DW-1:0] wdata,
    input  logic          err_set,
    input  logic          halt_set,
    output logic          en,
    output logic          err,
    output logic          halt
);
    // Enable register: follows written bit.
    always_ff @(posedge clk) begin
        if (!rst_n)  en <= 1'b0;
        else if (we) en <= wdata[BIT_EN];
    end

    // Error flag: set by hardware, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                      err <= 1'b0;
        else if (err_set)                err <= 1'b1;
        else if (we && !wdata[BIT_ERR])  err <= 1'b0;
    end

    // Halt flag: set by hardware, cleared by writing 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                      halt <= 1'b0;
        else if (halt_set)               halt <= 1'b1;
        else if (we && !wdata[BIT_HALT]) halt <= 1'b0;
    end

    AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (en == $past(wdata[BIT_EN]))); // R2
    AST_ERR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(err_set)); // R3
    AST_HALT_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt) |-> $past(halt_set)); // R3
endmodule

// File: rtl/dma_irq_pend.sv
// Module: per-channel rising-edge interrupt capture with write-zero clear.
// Assumes chan_irq is synchronous; a new edge beats a clearing write.
module dma_irq_pend #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [NCH-1:0] keep,
    input  logic [NCH-1:0] chan_irq,
    output logic [NCH-1:0] pend
);
    logic [NCH-1:0] irq_q;
    logic [NCH-1:0] rise;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        // Edge detector: remember last request level.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_q[n] <= 1'b0;
            else        irq_q[n] <= chan_irq[n];
        end
        assign rise[n] = chan_irq[n] & ~irq_q[n];
        // Pending bit: edge sets, write-zero clears.
        always_ff @(posedge clk) begin
            if (!rst_n)             pend[n] <= 1'b0;
            else if (rise[n])       pend[n] <= 1'b1;
            else if (we && !keep[n]) pend[n] <= 1'b0;
        end
    end

    AST_PEND_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise) |=> ((pend & $past(rise)) == $past(rise))); // R5
    AST_PEND_NOSET: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((pend & ~$past(keep) & ~$past(rise)) == '0)); // R6
    AST_PEND_ONLY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(rise)) == '0)); // R5
endmodule

// File: rtl/dma_doorbell.sv
// Module: doorbell bits set through a write-one-to-set alias, cleared by channel ack.
// Assumes set_we is a one-cycle strobe; a set beats an ack on the same bit.
module dma_doorbell #(
    parameter int NCH = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set_we,
    input  logic [NCH-1:0] set_mask,
    input  logic [NCH-1:0] ack,
    output logic [NCH-1:0] db
);
    logic [NCH-1:0] set_v;
    assign set_v = set_we ? set_mask : '0;

    for (genvar n = 0; n < NCH; n++) begin : g_db
        // Doorbell bit: alias set wins, ack clears.
        always_ff @(posedge clk) begin
            if (!rst_n)        db[n] <= 1'b0;
            else if (set_v[n]) db[n] <= 1'b1;
            else if (ack[n])   db[n] <= 1'b0;
        end
    end

    AST_DB_SET: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((db & $past(set_mask)) == $past(set_mask))); // R9
    AST_DB_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ack & ~set_v)) |=> ((db & $past(ack & ~set_v)) == '0)); // R11
endmodule

// File: rtl/dma_glb_ctrl.sv
// Module: top of the DMA global control and interrupt aggregator.
// Assumes NCH <= 32, single-cycle register writes, combinational reads.
module dma_glb_ctrl
    import dma_glb_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_sel,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              err_set,
    input  logic              halt_set,
    input  logic [NCH-1:0]    chan_irq,
    input  logic [NCH-1:0]    db_ack,
    output logic [NCH-1:0]    db_vec,
    output logic              glb_en,
    output logic              start_ok,
    output logic              irq_out
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PEND);
    localparam logic [ADDR_W-1:0] A_DBELL = ADDR_W'(OFS_DBELL);
    localparam logic [ADDR_W-1:0] A_DBSET = ADDR_W'(OFS_DBSET);

    logic           wr;
    logic           ctrl_we, pend_we, dbset_we;
    logic           err_f, halt_f;
    logic [NCH-1:0] pend;

    // Address decode for write strobes.
    assign wr       = reg_sel & reg_wr;
    assign ctrl_we  = wr && (reg_addr == A_CTRL);
    assign pend_we  = wr && (reg_addr == A_PEND);
    assign dbset_we = wr && (reg_addr == A_DBSET);

    dma_glb_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (ctrl_we),
        .wdata    (reg_wdata),
        .err_set  (err_set),
        .halt_set (halt_set),
        .en       (glb_en),
        .err      (err_f),
        .halt     (halt_f)
    );

    dma_irq_pend #(.NCH(NCH)) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (pend_we),
        .keep     (reg_wdata[NCH-1:0]),
        .chan_irq (chan_irq),
        .pend     (pend)
    );

    dma_doorbell #(.NCH(NCH)) u_db (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (dbset_we),
        .set_mask (reg_wdata[NCH-1:0]),
        .ack      (db_ack),
        .db       (db_vec)
    );

    // Global outputs: start permit and combined interrupt.
    assign start_ok = glb_en & ~err_f & ~halt_f;
    assign irq_out  = glb_en & (|pend);

    // Read mux: zero-extend vectors, zero for unmapped offsets.
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_CTRL) begin
            reg_rdata[BIT_EN]   = glb_en;
            reg_rdata[BIT_ERR]  = err_f;
            reg_rdata[BIT_HALT] = halt_f;
        end else if (reg_addr == A_PEND) begin
            reg_rdata[NCH-1:0] = pend;
        end else if (reg_addr == A_DBELL) begin
            reg_rdata[NCH-1:0] = db_vec;
        end
    end

    AST_DB_RO: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && (reg_addr == A_DBELL) && (db_ack == '0)) |=> $stable(db_vec)); // R10
endmodule

// File: tb/tb_dma_glb_ctrl.sv
module tb_dma_glb_ctrl;
    localparam int NCH = 32;
    localparam int AW  = 13;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           reg_sel = 1'b0, reg_wr = 1'b0;
    logic [AW-1:0]  reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic           err_set = 1'b0, halt_set = 1'b0;
    logic [NCH-1:0] chan_irq = '0, db_ack = '0, db_vec;
    logic           glb_en, start_ok, irq_out;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dma_glb_ctrl #(.NCH(NCH), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .err_set(err_set), .halt_set(halt_set), .chan_irq(chan_irq),
        .db_ack(db_ack), .db_vec(db_vec), .glb_en(glb_en),
        .start_ok(start_ok), .irq_out(irq_out)
    );

    localparam logic [AW-1:0] CTRL = 13'h1000, PEND = 13'h1004,
                              DBEL = 13'h1008, DBST = 13'h100C;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_sel = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        reg_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(CTRL, v); chk("R1 ctrl", v, 32'h0);
        rd(PEND, v); chk("R1 pend", v, 32'h0);
        rd(DBEL, v); chk("R1 dbell", v, 32'h0);
        chk("R1 outs", {29'b0, glb_en, start_ok, irq_out}, 32'h0);
    endtask

    task automatic t_ctrl();
        logic [31:0] v;
        wr(CTRL, 32'hFFFF_FFF1);
        rd(CTRL, v); chk("R2 enable readback", v, 32'h1);
        chk("R4 start_ok enabled", {31'b0, start_ok}, 32'h1);
        @(negedge clk); err_set = 1'b1; @(negedge clk); err_set = 1'b0;
        rd(CTRL, v); chk("R3 err set", v, 32'h5);
        chk("R4 blocked by err", {31'b0, start_ok}, 32'h0);
        wr(CTRL, 32'h5);
        rd(CTRL, v); chk("R3 write1 keeps err", v, 32'h5);
        @(negedge clk); halt_set = 1'b1;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = CTRL; reg_wdata = 32'h1;
        @(negedge clk); halt_set = 1'b0; reg_sel = 1'b0; reg_wr = 1'b0;
        rd(CTRL, v); chk("R3 set beats clear, err cleared", v, 32'h9);
        chk("R4 blocked by halt", {31'b0, start_ok}, 32'h0);
        wr(CTRL, 32'h1);
        rd(CTRL, v); chk("R3 halt cleared", v, 32'h1);
        chk("R4 start_ok again", {31'b0, start_ok}, 32'h1);
        wr(CTRL, 32'h0);
        rd(CTRL, v); chk("R2 disable readback", v, 32'h0);
        chk("R4 disabled", {31'b0, start_ok}, 32'h0);
        wr(CTRL, 32'h1);
    endtask

    task automatic t_pend();
        logic [31:0] v;
        @(negedge clk); chan_irq[0] = 1'b1; chan_irq[31] = 1'b1;
        @(negedge clk);
        rd(PEND, v); chk("R5 edge sets", v, 32'h8000_0001);
        chk("R8 irq with enable", {31'b0, irq_out}, 32'h1);
        wr(CTRL, 32'h0);
        chk("R8 irq gated off", {31'b0, irq_out}, 32'h0);
        wr(CTRL, 32'h1);
        wr(PEND, 32'h7FFF_FFFE);
        rd(PEND, v); chk("R6 write-zero clears, write-one no set", v, 32'h0);
        repeat (3) @(negedge clk);
        rd(PEND, v); chk("R5 held high no reset", v, 32'h0);
        chk("R8 no pending no irq", {31'b0, irq_out}, 32'h0);
        @(negedge clk); chan_irq = '0; chan_irq[5] = 1'b1;
        @(negedge clk); chan_irq[5] = 1'b0; chan_irq[9] = 1'b1;
        @(negedge clk);
        wr(PEND, 32'hFFFF_FDFF);
        rd(PEND, v); chk("R6 selective clear", v, 32'h20);
        @(negedge clk);
        chan_irq[5] = 1'b1;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = PEND; reg_wdata = 32'h0;
        @(negedge clk); reg_sel = 1'b0; reg_wr = 1'b0;
        rd(PEND, v); chk("R7 new edge beats clear", v, 32'h20);
        wr(PEND, 32'h0); chan_irq = '0;
    endtask

    task automatic t_db();
        logic [31:0] v;
        wr(DBST, 32'h8000_0009);
        wr(DBST, 32'h0000_0010);
        rd(DBEL, v); chk("R9 set alias accumulates", v, 32'h8000_0019);
        chk("R10 db_vec output", db_vec, 32'h8000_0019);
        rd(DBST, v); chk("R9 alias reads zero", v, 32'h0);
        wr(DBEL, 32'h0);
        rd(DBEL, v); chk("R10 write to dbell ignored", v, 32'h8000_0019);
        @(negedge clk); db_ack[0] = 1'b1; db_ack[31] = 1'b1;
        @(negedge clk); db_ack = '0;
        rd(DBEL, v); chk("R11 ack clears", v, 32'h18);
        @(negedge clk); db_ack[3] = 1'b1;
        reg_sel = 1'b1; reg_wr = 1'b1; reg_addr = DBST; reg_wdata = 32'h8;
        @(negedge clk); db_ack = '0; reg_sel = 1'b0; reg_wr = 1'b0;
        rd(DBEL, v); chk("R11 set beats ack", v, 32'h18);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(13'h1010, 32'hFFFF_FFFF);
        wr(13'h0000, 32'h0);
        rd(13'h1010, v); chk("R12 unmapped reads zero", v, 32'h0);
        rd(CTRL, v); chk("R12 ctrl untouched", v, 32'h1);
        rd(DBEL, v); chk("R12 dbell untouched", v, 32'h18);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_ctrl();
        t_pend();
        t_db();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule